// File: doc/BRIEF.md
# Serial CRC-8 Checker for 64-bit Registration Numbers

This block checks a 64-bit identification number that arrives one bit at a time, least significant bit first. It sits behind a single-line serial bus receiver. Each accepted bit is presented on `bit_in` with a one-cycle `bit_valid` strobe. The first 56 bits hold an 8-bit type byte and a 48-bit serial field. They are folded into an 8-stage CRC register built on the polynomial x^8 + x^5 + x^4 + 1, with the incoming bit entering at the x^8 feedback point. The last 8 bits are the transmitted check byte. The block captures them unchanged and compares them with the accumulated CRC.

Once the 64th bit is accepted, the block raises `done` and reports the comparison on `crc_ok`. It then ignores further strobes until a synchronous clear starts a new frame. The running CRC value is always visible on `crc_out`.

Top module: `regnum_crc_checker`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `crc_out` = 00h, `done` = 0 and `crc_ok` = 0. The frame position also returns to the first bit.
- R2: For each of the first 56 accepted bits, `crc_out` updates one cycle after the strobe. The update forms f = crc_out[0] XOR bit_in, shifts the register right by one, and XORs the constant 8Ch into the result when f is 1. This places f in bit 7 and XORs it into bits 3 and 2.
- R3: A cycle with `bit_valid` low changes neither `crc_out`, `done`, `crc_ok` nor the frame position, whatever `bit_in` holds.
- R4: Accepted bits 57 to 64 leave `crc_out` unchanged. They form the received check byte: bit 57 is its bit 0 and bit 64 is its bit 7.
- R5: `done` rises in the cycle after the 64th accepted bit. It stays high until a clear.
- R6: `crc_ok` is 1 when `done` is high and the received check byte equals `crc_out`. Otherwise it is 0. In particular it is 0 whenever `done` is low.
- R7: While `done` is high, strobes on `bit_valid` change none of the outputs.
- R8: A clear in the middle of a frame discards the partial frame. The next accepted bit is treated as bit 1 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| bit_in | input | 1 | Serial data bit, LSB of the number first |
| bit_valid | input | 1 | Strobe: `bit_in` is accepted on this edge |
| crc_out | output | 8 | Running CRC over the first 56 bits |
| done | output | 1 | All 64 bits received |
| crc_ok | output | 1 | Check byte matches the computed CRC (valid while `done`) |

## Verification
The hardest situation to reach is the boundary between the accumulate and compare phases when strobes are irregular. Here the frame position has to advance only on accepted bits, and idle cycles carry misleading data on `bit_in`. The stimulus sends frames with idle cycles interleaved and the idle bit inverted. It also places a clear partway through a frame and then sends a complete new frame. Corrupted check bytes at bit 0 and bit 7 test whether the final compare includes the very last bit in the same cycle as it arrives.

// File: rtl/regnum_crc_pkg.sv
package regnum_crc_pkg;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_CHECK = 2'd1,
    PH_DONE  = 2'd2
  } frame_phase_e;

  localparam int unsigned DEF_CRC_W     = 8;
  localparam int unsigned DEF_DATA_BITS = 56;
  localparam logic [7:0]  DEF_POLY_REFL = 8'h8C;

endpackage

// File: rtl/frame_bit_counter.sv
module frame_bit_counter
  import regnum_crc_pkg::*;
#(
  parameter int unsigned DATA_BITS  = 56,
  parameter int unsigned CHECK_BITS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_valid,
  output logic         accept,
  output frame_phase_e phase,
  output logic         last_bit,
  output logic         done
);
  localparam int unsigned TOTAL = DATA_BITS + CHECK_BITS;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign accept   = bit_valid && !done_q;
  assign last_bit = accept && (cnt_q == CW'(TOTAL - 1));
  assign done     = done_q;

  always_comb begin
    if (done_q)                        phase = PH_DONE;
    else if (cnt_q < CW'(DATA_BITS))   phase = PH_DATA;
    else                               phase = PH_CHECK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(TOTAL - 1)) done_q <= 1'b1;
    end
  end

  assert_done_rise_R5: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> done_q);
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(cnt_q));
endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic         fb;
  logic [W-1:0] crc_next;

  assign fb = crc_q[0] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_top
      assign crc_next[i] = POLY[i] & fb;
    end else begin : g_mid
      assign crc_next[i] = crc_q[i+1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= '0;
    else if (load) crc_q <= crc_next;
  end

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (crc_q == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(crc_q));
endmodule

// File: rtl/check_capture.sv
module check_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         finish,
  input  logic         din,
  input  logic [W-1:0] crc_in,
  output logic         ok_q
);
  logic [W-1:0] rx_q;
  logic [W-1:0] rx_full;

  assign rx_full = {din, rx_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
      ok_q <= 1'b0;
    end else begin
      if (shift_en) rx_q <= rx_full;
      if (finish)   ok_q <= (rx_full == crc_in);
    end
  end

  assert_ok_only_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    (!finish && !ok_q) |=> !ok_q);
endmodule

// File: rtl/regnum_crc_checker.sv
module regnum_crc_checker
  import regnum_crc_pkg::*;
#(
  parameter int unsigned  CRC_W     = DEF_CRC_W,
  parameter int unsigned  DATA_BITS = DEF_DATA_BITS,
  parameter logic [CRC_W-1:0] POLY  = DEF_POLY_REFL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic [CRC_W-1:0] crc_out,
  output logic             done,
  output logic             crc_ok
);
  logic         accept;
  logic         last_bit;
  frame_phase_e phase;
  logic         crc_load;
  logic         chk_shift;

  assign crc_load  = accept && (phase == PH_DATA);
  assign chk_shift = accept && (phase == PH_CHECK);

  frame_bit_counter #(
    .DATA_BITS (DATA_BITS),
    .CHECK_BITS(CRC_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bit_valid(bit_valid),
    .accept   (accept),
    .phase    (phase),
    .last_bit (last_bit),
    .done     (done)
  );

  crc_accum #(
    .W   (CRC_W),
    .POLY(POLY)
  ) u_crc (
    .clk  (clk),
    .rst  (rst),
    .load (crc_load),
    .din  (bit_in),
    .crc_q(crc_out)
  );

  check_capture #(
    .W(CRC_W)
  ) u_chk (
    .clk     (clk),
    .rst     (rst),
    .shift_en(chk_shift),
    .finish  (last_bit),
    .din     (bit_in),
    .crc_in  (crc_out),
    .ok_q    (crc_ok)
  );

  assert_ok_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> !crc_ok);
  assert_check_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && phase == PH_CHECK) |=> $stable(crc_out));
  assert_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(crc_out) && $stable(crc_ok)));
  assert_clear_outs_R1: assert property (@(posedge clk)
    rst |=> (!done && !crc_ok));
endmodule

// File: tb/regnum_crc_checker_tb.sv
module regnum_crc_checker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       bit_valid = 1'b0;
  logic [7:0] crc_out;
  logic       done;
  logic       crc_ok;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int       m_cnt  = 0;
  bit [7:0] m_crc  = '0;
  bit [7:0] m_rx   = '0;
  bit       m_done = 0;
  bit       m_ok   = 0;

  always #2 clk = ~clk;

  regnum_crc_checker u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .crc_out(crc_out), .done(done), .crc_ok(crc_ok)
  );

  function automatic bit [7:0] ref_crc(input bit [55:0] body);
    bit [7:0] c = '0;
    for (int i = 0; i < 56; i++) begin
      bit f = c[0] ^ body[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic bit [63:0] make_frame(input bit [55:0] body);
    return {ref_crc(body), body};
  endfunction

  task automatic model_edge(input bit b, input bit v, input bit r);
    if (r) begin
      m_cnt = 0; m_crc = '0; m_rx = '0; m_done = 0; m_ok = 0;
    end else if (v && !m_done) begin
      if (m_cnt < 56) begin
        bit f = m_crc[0] ^ b;
        m_crc = m_crc >> 1;
        if (f) m_crc = m_crc ^ 8'h8C;
      end else begin
        m_rx[m_cnt - 56] = b;
        if (m_cnt == 63) begin
          m_done = 1;
          m_ok   = (m_rx == m_crc);
        end
      end
      m_cnt++;
    end
  endtask

  task automatic tick(input bit b, input bit v, input bit r, input string tag);
    bit_in = b; bit_valid = v; rst = r;
    @(posedge clk);
    model_edge(b, v, r);
    @(negedge clk);
    checks++;
    if (crc_out !== m_crc || done !== m_done || crc_ok !== m_ok) begin
      fails++;
      $display("FAIL %s: crc_out=%h done=%b crc_ok=%b expected crc_out=%h done=%b crc_ok=%b",
               tag, crc_out, done, crc_ok, m_crc, m_done, m_ok);
    end
  endtask

  task automatic send_frame(input bit [63:0] fr, input bit gaps, input string okt);
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 3 == 1)) tick(~fr[i], 1'b0, 1'b0, "R3 idle");
      if (i < 56)       tick(fr[i], 1'b1, 1'b0, "R2 accumulate");
      else if (i < 63)  tick(fr[i], 1'b1, 1'b0, "R4 check byte");
      else              tick(fr[i], 1'b1, 1'b0, okt);
    end
  endtask

  task automatic clear();
    tick(1'b1, 1'b1, 1'b1, "R1 clear");
  endtask

  initial begin
    bit [63:0] fa, fb;
    @(negedge clk);
    tick(1'b0, 1'b0, 1'b1, "R1 reset");
    tick(1'b1, 1'b1, 1'b1, "R1 reset with strobe");

    fa = make_frame(56'h1A2B3C4D5E6F_01);
    send_frame(fa, 1'b0, "R5 R6 good frame");
    for (int k = 0; k < 5; k++) tick(k[0], 1'b1, 1'b0, "R7 strobe after done");
    tick(1'b1, 1'b0, 1'b0, "R3 idle after done");

    clear();
    fb = fa ^ (64'h01 << 56);
    send_frame(fb, 1'b0, "R6 check bit0 corrupted");

    clear();
    fb = fa ^ (64'h80 << 56);
    send_frame(fb, 1'b0, "R6 check bit7 corrupted");

    clear();
    send_frame(64'h0, 1'b0, "R6 all-zero frame");

    clear();
    send_frame(make_frame(56'hFFFFFFFFFFFFFF), 1'b1, "R3 R6 gapped frame");

    clear();
    for (int i = 0; i < 20; i++) tick(i[1], 1'b1, 1'b0, "R2 partial");
    tick(1'b0, 1'b1, 1'b1, "R8 mid-frame clear");
    send_frame(make_frame(56'h00C0FFEE123456), 1'b1, "R8 frame after clear");

    clear();
    for (int i = 0; i < 60; i++) tick(i[0] ^ i[2], 1'b1, 1'b0, "R4 partial check");
    tick(1'b1, 1'b1, 1'b1, "R8 clear in check phase");
    send_frame(make_frame(56'h5A5A5A5A5A5A5A), 1'b0, "R8 R5 frame after check clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule